// File: doc/BRIEF.md
# Two-Phase Bus Cycle Sequencer

This block is the master-side controller for one transfer on a shared 16-bit data bus that is timed by two interleaved clock phases, A and B. A host asks for one transfer by pulsing `start` together with a cycle kind, an address and, for writes, a data word. The block then requests the bus and waits for the priority grant. Once granted, it runs a fixed strobe sequence of address, then write data, then read data. Each step advances only on a phase-B clock.

Both phases come from a single synchronous clock. They appear as alternating one-clock enable pulses, so one bus period is two system clocks (A, then B). All bus inputs pass through a synchroniser of `SYNC_STAGES` flops before use. A hold input can stretch the middle of the cycle. If hold stays low too long, a timeout abandons the cycle and reports an error. A sticky flag records whether a peripheral acknowledged an order during a peripheral cycle.

Top module: `bus_cycle_seq`

## Requirements
- R1: `ph_a` and `ph_b` are alternating one-clock pulses. Exactly one of them is high in every clock, and `ph_a` is high in the first clock after reset.
- R2: During and right after reset, all active-low bus outputs are high, `bus_oe`, `busy`, `done`, `err` and `acc_flag` are 0, and `rdata` is 0.
- R3: A `start` accepted while idle drives `req_n` low. The grant is taken only in a `ph_b` clock in which the synchronised `grant_n` is low. Until then `req_n` stays low and no strobe or kind line is asserted. `req_n` rises when the grant is taken.
- R4: `ads_n` is low for exactly one bus period (two clocks) right after the grant. During that period `bus_oe` is 1 and `bus_out` equals the latched address.
- R5: From the address period to the end of the final period, exactly one bit of `kind_n` is low, and the bit index is the kind code. The codes are 0 write memory, 1 read memory, 2 write peripheral and 3 read peripheral. Bit 0 of the code means read and bit 1 means peripheral.
- R6: On write kinds, `wds_n` is low from the period after the address period through the final period, which is at least two periods. During that time `bus_out` equals the latched write word.
- R7: `rds_n` is low only in the final period. On read kinds, `bus_in` is captured into `rdata` in the `ph_a` clock of that period. `done` pulses for one clock after the final period ends.
- R8: If the synchronised `hold_n` is low at the `ph_b` clock that would end the middle period, the middle period is repeated. The final period begins on the period after a `ph_b` sample that sees hold high.
- R9: If hold is seen low at `HOLD_LIMIT` consecutive middle-period `ph_b` samples, the cycle is abandoned with no read strobe. `err` then pulses for one clock, `done` stays low, and the block returns to idle.
- R10: `acc_flag` is set if the synchronised `accept_n` is low in any clock from the address period to the final period of a peripheral cycle. Memory cycles leave it unchanged. It clears when the next peripheral cycle is granted.
- R11: `bus_oe` is 1 only during the address strobe or the write strobe. `bus_out` is 0 whenever `bus_oe` is 0.
- R12: `start` has no effect while `busy` is 1. The kind, address and data in use, and the return to idle after the cycle, are unchanged by it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin one transfer (taken only while idle) |
| kind | input | 2 | Cycle kind code (see R5) |
| addr | input | 16 | Transfer address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Data captured on read cycles |
| busy | output | 1 | A transfer is pending or running |
| done | output | 1 | One-clock pulse at normal completion |
| err | output | 1 | One-clock pulse on hold timeout |
| acc_flag | output | 1 | Peripheral order-accepted flag |
| ph_a | output | 1 | Phase-A enable pulse |
| ph_b | output | 1 | Phase-B enable pulse |
| req_n | output | 1 | Active-low bus request |
| grant_n | input | 1 | Active-low priority grant |
| ads_n | output | 1 | Active-low address strobe |
| wds_n | output | 1 | Active-low write data strobe |
| rds_n | output | 1 | Active-low read data strobe |
| kind_n | output | 4 | Active-low cycle kind lines, one per code |
| hold_n | input | 1 | Active-low cycle hold |
| accept_n | input | 1 | Active-low peripheral order accepted |
| bus_in | input | 16 | Data bus as received |
| bus_out | output | 16 | Data bus as driven |
| bus_oe | output | 1 | Drive enable for `bus_out` |

## Verification
The properties assume that `grant_n`, `hold_n` and `accept_n` are plain levels, change at most once per system clock, and are meaningful only after the synchroniser delay. They also assume that the host treats `start` as a request and not as a cancel. The bench changes every input only on falling clock edges, holds hold steady across whole periods, and releases hold before the timeout in all cases except the one that tests the timeout. A behavioural model in the bench replays the same inputs and is compared against every output on every clock.

// File: rtl/bcs_pkg.sv
// Package: shared types for the two-phase bus cycle sequencer.
// Assumes: kind code bit 0 = read, bit 1 = peripheral.
package bcs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_REQ  = 3'd1,
        ST_ADDR = 3'd2,
        ST_MID  = 3'd3,
        ST_LAST = 3'd4
    } seq_state_t;

    typedef enum logic [1:0] {
        CY_WR_MEM = 2'b00,
        CY_RD_MEM = 2'b01,
        CY_WR_PER = 2'b10,
        CY_RD_PER = 2'b11
    } cyc_kind_t;

    // True for kinds that move data toward the master.
    function automatic logic kind_is_read(cyc_kind_t k);
        return k[0];
    endfunction

    // True for kinds that address a peripheral rather than memory.
    function automatic logic kind_is_periph(cyc_kind_t k);
        return k[1];
    endfunction

endpackage

// File: rtl/bcs_phase_gen.sv
// Module: derives the two interface phases from one clock.
// Behaviour: ph_a and ph_b are alternating one-clock enables; ph_a first
// after reset. Assumes a synchronous active-low reset.
module bcs_phase_gen (
    input  logic clk,
    input  logic rst_n,
    output logic ph_a,
    output logic ph_b
);
    logic sel_q;

    // Toggle the phase selector every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= 1'b0;
        else        sel_q <= ~sel_q;
    end

    assign ph_a = ~sel_q;
    assign ph_b = sel_q;
endmodule

// File: rtl/bcs_sync.sv
// Module: multi-flop synchroniser for a bundle of asynchronous levels.
// Assumes: each bit is an independent level; STAGES >= 1.
module bcs_sync #(
    parameter int            WIDTH     = 3,
    parameter int            STAGES    = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] pipe_q;

    // Shift the sampled levels down the chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe_q[i] <= RST_VAL;
        end else begin
            pipe_q[0] <= din;
            for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
        end
    end

    assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/bcs_hold_timer.sv
// Module: counts consecutive held phase-B samples in the middle period.
// Behaviour: expire is high in the tick that would be the LIMIT-th
// consecutive held sample. Count clears whenever active is low.
module bcs_hold_timer #(
    parameter int LIMIT = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic tick,
    input  logic held,
    output logic expire
);
    localparam int CW = $clog2(LIMIT + 1);
    logic [CW-1:0] cnt_q;

    // Count held samples while the middle period lasts.
    always_ff @(posedge clk) begin
        if (!rst_n || !active)  cnt_q <= '0;
        else if (tick && held)  cnt_q <= cnt_q + 1'b1;
    end

    assign expire = active && tick && held && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/bus_cycle_seq.sv
// Module: master-side sequencer for one transfer on a two-phase bus.
// Behaviour: request -> grant on ph_b -> address period -> middle period
// (repeatable under hold) -> final period, then idle. Kind lines are held
// from the address period through the final period.
// Assumes: bus inputs are asynchronous levels; kind/addr/wdata valid with start.
module bus_cycle_seq #(
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_LIMIT  = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        kind,
    input  logic [DATA_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              acc_flag,
    output logic              ph_a,
    output logic              ph_b,
    output logic              req_n,
    input  logic              grant_n,
    output logic              ads_n,
    output logic              wds_n,
    output logic              rds_n,
    output logic [3:0]        kind_n,
    input  logic              hold_n,
    input  logic              accept_n,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe
);
    import bcs_pkg::*;

    localparam int NUM_KINDS = 4;
    localparam int NSYNC     = 3;

    seq_state_t        state_q, state_d;
    cyc_kind_t         kind_q;
    logic [DATA_W-1:0] addr_q, wdata_q, rdata_q;
    logic              done_q, err_q, acc_q;
    logic [NSYNC-1:0]  sync_out;
    logic              grant_s, hold_s, accept_s;
    logic              in_cycle, is_write, take_grant, expire;

    bcs_phase_gen u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .ph_a  (ph_a),
        .ph_b  (ph_b)
    );

    bcs_sync #(
        .WIDTH   (NSYNC),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({NSYNC{1'b1}})
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({grant_n, hold_n, accept_n}),
        .dout  (sync_out)
    );

    assign {grant_s, hold_s, accept_s} = sync_out;

    bcs_hold_timer #(
        .LIMIT (HOLD_LIMIT)
    ) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (state_q == ST_MID),
        .tick   (ph_b),
        .held   (~hold_s),
        .expire (expire)
    );

    assign in_cycle   = (state_q == ST_ADDR) || (state_q == ST_MID) || (state_q == ST_LAST);
    assign is_write   = ~kind_is_read(kind_q);
    assign take_grant = (state_q == ST_REQ) && ph_b && !grant_s;

    // Next-state selection; bus steps only advance on ph_b.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start)      state_d = ST_REQ;
            ST_REQ:  if (take_grant) state_d = ST_ADDR;
            ST_ADDR: if (ph_b)       state_d = ST_MID;
            ST_MID: begin
                if (ph_b) begin
                    if (hold_s)      state_d = ST_LAST;
                    else if (expire) state_d = ST_IDLE;
                end
            end
            ST_LAST: if (ph_b)       state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Latch the request parameters when a start is accepted while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q  <= CY_WR_MEM;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (state_q == ST_IDLE && start) begin
            kind_q  <= cyc_kind_t'(kind);
            addr_q  <= addr;
            wdata_q <= wdata;
        end
    end

    // Capture read data on the phase-A clock of the final period.
    always_ff @(posedge clk) begin
        if (!rst_n)                                               rdata_q <= '0;
        else if (state_q == ST_LAST && ph_a && kind_is_read(kind_q)) rdata_q <= bus_in;
    end

    // Completion and timeout pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= (state_q == ST_LAST) && ph_b;
            err_q  <= (state_q == ST_MID) && ph_b && !hold_s && expire;
        end
    end

    // Set-only order-accepted flag, cleared at each peripheral grant.
    always_ff @(posedge clk) begin
        if (!rst_n)                                                acc_q <= 1'b0;
        else if (take_grant && kind_is_periph(kind_q))             acc_q <= 1'b0;
        else if (in_cycle && kind_is_periph(kind_q) && !accept_s)  acc_q <= 1'b1;
    end

    // One active-low line per cycle kind.
    for (genvar g = 0; g < NUM_KINDS; g++) begin : g_kind
        assign kind_n[g] = ~(in_cycle && (kind_q == cyc_kind_t'(g)));
    end

    // Strobes and the bus driver derived from the current period.
    always_comb begin
        req_n  = (state_q != ST_REQ);
        ads_n  = (state_q != ST_ADDR);
        wds_n  = ~(is_write && (state_q == ST_MID || state_q == ST_LAST));
        rds_n  = (state_q != ST_LAST);
        bus_oe = (state_q == ST_ADDR) || !wds_n;
        if (state_q == ST_ADDR) bus_out = addr_q;
        else if (!wds_n)        bus_out = wdata_q;
        else                    bus_out = '0;
    end

    assign busy     = (state_q != ST_IDLE);
    assign done     = done_q;
    assign err      = err_q;
    assign acc_flag = acc_q;
    assign rdata    = rdata_q;
endmodule

// File: rtl/bcs_checker.sv
// Module: protocol properties for bus_cycle_seq, bound to every instance.
// Assumes: observes top-level ports only.
module bcs_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       ph_a,
    input logic       ph_b,
    input logic       req_n,
    input logic       ads_n,
    input logic       wds_n,
    input logic       rds_n,
    input logic [3:0] kind_n,
    input logic       bus_oe,
    input logic       done,
    input logic       err,
    input logic       acc_flag
);
    assert_phase_a_then_b_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ph_a |=> ph_b);
    assert_phase_b_then_a_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ph_b |=> ph_a);
    assert_req_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !req_n |-> (&kind_n && ads_n && wds_n && rds_n));
    assert_ads_starts_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ads_n && ph_a) |=> !ads_n);
    assert_ads_ends_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ads_n && ph_b) |=> ads_n);
    assert_kind_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~kind_n) <= 1);
    assert_kind_in_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ads_n || !wds_n || !rds_n) |-> ($countones(~kind_n) == 1));
    assert_rds_alone_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rds_n |-> ads_n);
    assert_done_after_rds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !$past(rds_n));
    assert_err_no_rds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> ($past(rds_n) && !done));
    assert_acc_periph_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(acc_flag) |-> (!$past(kind_n[2]) || !$past(kind_n[3])));
    assert_oe_window_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (!ads_n || !wds_n));
endmodule

bind bus_cycle_seq bcs_checker u_bcs_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .ph_a     (ph_a),
    .ph_b     (ph_b),
    .req_n    (req_n),
    .ads_n    (ads_n),
    .wds_n    (wds_n),
    .rds_n    (rds_n),
    .kind_n   (kind_n),
    .bus_oe   (bus_oe),
    .done     (done),
    .err      (err),
    .acc_flag (acc_flag)
);

// File: tb/bus_cycle_seq_bench.sv
// Bench: behavioural reference model compared every clock, plus directed checks.
module bus_cycle_seq_bench;
    localparam int LIM = 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  kind = 2'b00;
    logic [15:0] addr = '0, wdata = '0, bus_in = 16'hA5C3;
    logic        grant_n = 1'b1, hold_n = 1'b1, accept_n = 1'b1;
    logic [15:0] rdata, bus_out;
    logic        busy, done, err, acc_flag, ph_a, ph_b, req_n, ads_n, wds_n, rds_n, bus_oe;
    logic [3:0]  kind_n;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int ads_c, wds_c, rds_c;

    bus_cycle_seq #(.HOLD_LIMIT(LIM)) u_bus_cycle_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .kind(kind), .addr(addr), .wdata(wdata),
        .rdata(rdata), .busy(busy), .done(done), .err(err), .acc_flag(acc_flag),
        .ph_a(ph_a), .ph_b(ph_b), .req_n(req_n), .grant_n(grant_n), .ads_n(ads_n),
        .wds_n(wds_n), .rds_n(rds_n), .kind_n(kind_n), .hold_n(hold_n),
        .accept_n(accept_n), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    // ---- behavioural reference model ----
    int         m_st;
    bit         m_sel, m_valid = 0, m_done, m_err, m_acc;
    logic [2:0] m_s1, m_s2;
    int         m_hc;
    logic [1:0] m_kind;
    logic [15:0] m_addr, m_wd, m_rd;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_sel = 0; m_s1 = 3'b111; m_s2 = 3'b111; m_hc = 0;
            m_kind = 0; m_addr = 0; m_wd = 0; m_rd = 0;
            m_done = 0; m_err = 0; m_acc = 0; m_valid = 1;
        end else begin
            bit phb, pha, gs, hs, as_, nd, ne, incyc;
            int old;
            phb = m_sel; pha = !m_sel;
            gs = m_s2[2]; hs = m_s2[1]; as_ = m_s2[0];
            old = m_st;
            nd = (old == 4) && phb; ne = 0;
            incyc = (old >= 2);
            if (old == 4 && pha && m_kind[0]) m_rd = bus_in;
            if (old == 1 && phb && !gs && m_kind[1]) m_acc = 0;
            else if (incyc && m_kind[1] && !as_) m_acc = 1;
            case (old)
                0: if (start) begin m_st = 1; m_kind = kind; m_addr = addr; m_wd = wdata; end
                1: if (phb && !gs) m_st = 2;
                2: if (phb) m_st = 3;
                3: if (phb) begin
                       if (hs) m_st = 4;
                       else if (m_hc == LIM - 1) begin ne = 1; m_st = 0; end
                   end
                4: if (phb) m_st = 0;
                default: m_st = 0;
            endcase
            if (old != 3) m_hc = 0;
            else if (phb && !hs) m_hc++;
            m_done = nd; m_err = ne;
            m_s2 = m_s1; m_s1 = {grant_n, hold_n, accept_n};
            m_sel = !m_sel;
        end
    end

    // Compare every output with the model away from the active edge.
    always @(negedge clk) begin
        if (m_valid) begin
            bit wr, e_oe;
            logic [3:0]  e_kind;
            logic [15:0] e_out;
            wr = !m_kind[0];
            e_oe = (m_st == 2) || (wr && m_st >= 3);
            e_kind = (m_st >= 2) ? ~(4'b1 << m_kind) : 4'hF;
            e_out = (m_st == 2) ? m_addr : (e_oe ? m_wd : 16'h0);
            chk({ph_a, ph_b} == {!m_sel, m_sel}, "R1 phases", {ph_a, ph_b}, {!m_sel, m_sel});
            chk(req_n == (m_st != 1), "R3 req_n", req_n, (m_st != 1));
            chk(ads_n == (m_st != 2), "R4 ads_n", ads_n, (m_st != 2));
            chk(kind_n == e_kind, "R5 kind_n", kind_n, e_kind);
            chk(wds_n == !(wr && m_st >= 3), "R6 wds_n", wds_n, !(wr && m_st >= 3));
            chk(rds_n == (m_st != 4), "R7 rds_n", rds_n, (m_st != 4));
            chk(done == m_done, "R7 done", done, m_done);
            chk(rdata == m_rd, "R7 rdata", rdata, m_rd);
            chk(err == m_err, "R9 err", err, m_err);
            chk(acc_flag == m_acc, "R10 acc_flag", acc_flag, m_acc);
            chk(bus_oe == e_oe, "R11 bus_oe", bus_oe, e_oe);
            chk(bus_out == e_out, "R11 bus_out", bus_out, e_out);
            chk(busy == (m_st != 0), "R12 busy", busy, (m_st != 0));
        end
    end

    // Strobe length counters for directed checks.
    always @(negedge clk) begin
        if (!ads_n) ads_c++;
        if (!wds_n) wds_c++;
        if (!rds_n) rds_c++;
    end

    task automatic run(input logic [1:0] k, input logic [15:0] a, input logic [15:0] w, output bit got_err);
        ads_c = 0; wds_c = 0; rds_c = 0; got_err = 0;
        @(negedge clk); kind = k; addr = a; wdata = w; start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (done || err) break;
        end
        got_err = err;
    endtask

    // Watchdog: a hung run is a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        bit e;
        repeat (4) @(negedge clk);
        // R2: quiet outputs in reset
        chk({req_n, ads_n, wds_n, rds_n, kind_n} == 8'hFF, "R2 strobes in reset", {req_n, ads_n, wds_n, rds_n, kind_n}, 8'hFF);
        chk({bus_oe, busy, done, err, acc_flag} == 5'b0, "R2 status in reset", {bus_oe, busy, done, err, acc_flag}, 0);
        chk(rdata == 16'h0, "R2 rdata in reset", rdata, 0);
        rst_n = 1'b1;
        chk(ph_a == 1'b1, "R1 ph_a first after reset", ph_a, 1);
        grant_n = 1'b0;
        repeat (6) @(negedge clk);

        // Write memory, no hold
        run(2'd0, 16'h1234, 16'hBEEF, e);
        chk(ads_c == 2, "R4 address strobe length", ads_c, 2);
        chk(wds_c == 4, "R6 write strobe length", wds_c, 4);
        chk(rds_c == 2, "R7 read strobe length", rds_c, 2);
        chk(e == 0, "R7 normal completion", e, 0);

        // Read memory with a delayed grant
        grant_n = 1'b1;
        fork
            run(2'd1, 16'h00F0, 16'h0, e);
            begin
                repeat (12) @(negedge clk);
                chk(req_n == 1'b0 && ads_n == 1'b1, "R3 waiting for grant", {req_n, ads_n}, 2'b01);
                grant_n = 1'b0;
            end
        join
        chk(rdata == 16'hA5C3, "R7 read data captured", rdata, 16'hA5C3);
        chk(wds_c == 0, "R6 no write strobe on read", wds_c, 0);

        // Write peripheral with hold and an accept pulse
        hold_n = 1'b0;
        fork
            run(2'd2, 16'h0420, 16'h5A5A, e);
            begin
                repeat (3) @(negedge clk); accept_n = 1'b0;
                repeat (3) @(negedge clk); accept_n = 1'b1;
                repeat (14) @(negedge clk); hold_n = 1'b1;
            end
        join
        chk(wds_c > 4, "R8 hold stretches write strobe", wds_c, 5);
        chk(rds_c == 2, "R8 read strobe after hold", rds_c, 2);
        chk(acc_flag == 1'b1, "R10 flag set by accept", acc_flag, 1);

        // Memory cycle leaves the flag alone
        bus_in = 16'h3C3C;
        run(2'd1, 16'h0002, 16'h0, e);
        chk(acc_flag == 1'b1, "R10 memory cycle keeps flag", acc_flag, 1);
        chk(rdata == 16'h3C3C, "R7 second read data", rdata, 16'h3C3C);

        // Peripheral read without accept clears the flag; start while busy ignored
        fork
            run(2'd3, 16'h0808, 16'h0, e);
            begin
                repeat (4) @(negedge clk);
                kind = 2'd0; addr = 16'hFFFF; start = 1'b1;
                @(negedge clk); start = 1'b0;
            end
        join
        chk(acc_flag == 1'b0, "R10 cleared at peripheral grant", acc_flag, 0);
        repeat (8) @(negedge clk);
        chk(busy == 1'b0 && req_n == 1'b1, "R12 start while busy ignored", {busy, req_n}, 2'b01);

        // Hold timeout
        hold_n = 1'b0;
        run(2'd0, 16'h7777, 16'h1111, e);
        chk(e == 1'b1, "R9 timeout error", e, 1);
        chk(rds_c == 0, "R9 no read strobe on timeout", rds_c, 0);
        hold_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(busy == 1'b0, "R9 idle after timeout", busy, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule